// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level table that sits in ordinary memory. The linear address splits into three fields: a 10-bit directory index in bits 31..22, a 10-bit table index in bits 21..12, and a 12-bit page offset in bits 11..0. Every directory and table has 1024 four-byte entries, so each one fills a single 4 KB page. The upper 20 bits of an entry give a 4 KB-aligned base. Bit 0 of an entry is the present flag. Bit 1 (read/write) and bit 2 (user/supervisor) are carried in the entry but not checked.

The block holds two configuration values. The first is a paging-enable bit, written as bit 31 of a control word. The second is the upper 20 bits of the directory's address. When paging is off, a request returns its own address as the physical address and no memory is read. When paging is on, the block reads the directory entry and then the table entry through a 32-bit read port. It returns either the physical address or a fault. Only one translation is in flight at a time.

Top module: `ptw_two_level`

## Requirements
- R1: During and after a synchronous active-high reset: paging is disabled, the directory base is zero, `req_ready` is 1, and `rsp_valid` and `mem_valid` are 0.
- R2: With paging disabled, an accepted request gives `rsp_valid` in the very next cycle, with `rsp_phys` equal to the linear address and `rsp_fault` 0. No memory read is issued.
- R3: A control write (`ctrl_we`) sets the paging-enable bit from `ctrl_wdata[31]`. Bits 30..0 of the control word have no effect.
- R4: A base write (`base_we`) keeps `base_wdata[31:12]` as the directory base. Bits 11..0 are ignored, so the directory is always 4 KB aligned.
- R5: With paging enabled, the first memory read goes to address {base[31:12], lin[31:22], 2'b00}.
- R6: If the directory entry has bit 0 set, the second read goes to address {pde[31:12], lin[21:12], 2'b00}.
- R7: If the table entry has bit 0 set, the response has `rsp_fault` 0 and `rsp_phys` = {pte[31:12], lin[11:0]}.
- R8: If either fetched entry has bit 0 clear, the response has `rsp_fault` 1 and `rsp_phys` 0. A directory entry that is not present ends the walk after that one read.
- R9: Once `mem_valid` is raised, it and `mem_addr` hold steady until `mem_ready` is seen. Read data is taken only when `mem_rvalid` is high.
- R10: `req_ready` is high only while the walker is idle. A request presented while it is busy is not accepted.
- R11: Control and base writes presented while a translation is in flight are ignored.
- R12: `rsp_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word; bit 31 enables paging |
| base_we | input | 1 | Directory base write strobe |
| base_wdata | input | 32 | Directory address; bits 31..12 kept |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_lin | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Entry not present |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| mem_valid | output | 1 | Read request to memory |
| mem_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
A bypass response comes exactly one cycle after the accepting edge. The bench drives each request at a falling edge and requires `rsp_valid` at the next falling edge, with no read handshake seen. A paged response comes one cycle after the last `mem_rvalid`. Its arrival time depends on the random ready and data delays of the bench's memory model, so the bench waits for `rsp_valid` within a bounded number of cycles. It then checks the values and the fetch addresses, and requires `rsp_valid` to be low again one cycle later. Configuration writes made during a walk are judged by the behaviour of the translation that follows.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 12;
  localparam int TBL_W  = 10;
  localparam int ENT_SH = 2;
  localparam int DIR_W  = ADDR_W - OFF_W - TBL_W;
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam int PG_BIT = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_PDE, ST_WAIT_PDE, ST_FETCH_PTE, ST_WAIT_PTE, ST_DONE
  } walk_state_t;

  function automatic logic [ADDR_W-1:0] dir_entry_addr(
    input logic [BASE_W-1:0] base, input logic [ADDR_W-1:0] lin);
    return {base, lin[ADDR_W-1 -: DIR_W], {ENT_SH{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] tbl_entry_addr(
    input logic [BASE_W-1:0] tbase, input logic [ADDR_W-1:0] lin);
    return {tbase, lin[OFF_W+TBL_W-1 -: TBL_W], {ENT_SH{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] page_phys(
    input logic [BASE_W-1:0] pbase, input logic [ADDR_W-1:0] lin);
    return {pbase, lin[OFF_W-1:0]};
  endfunction

  function automatic logic entry_present(input logic [ADDR_W-1:0] ent);
    return ent[0];
  endfunction
endpackage

// File: rtl/pw_cfg.sv
module pw_cfg
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_allow,
  input  logic              ctrl_we,
  input  logic [ADDR_W-1:0] ctrl_wdata,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic              paging_on,
  output logic [BASE_W-1:0] dir_base
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{ctrl_wdata[PG_BIT-1:0], base_wdata[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      paging_on <= 1'b0;
      dir_base  <= '0;
    end else if (wr_allow) begin
      if (ctrl_we) paging_on <= ctrl_wdata[PG_BIT];
      if (base_we) dir_base  <= base_wdata[ADDR_W-1:OFF_W];
    end
  end
endmodule

// File: rtl/pw_walk.sv
module pw_walk
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              paging_on,
  input  logic [BASE_W-1:0] dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              ev_accept,
  output logic              ev_miss
);
  walk_state_t       state;
  logic [ADDR_W-1:0] lin_q;
  logic [BASE_W-1:0] tbase_q;
  logic              fault_q;
  logic [ADDR_W-1:0] phys_q;
  logic              hit;
  logic              unused_ent_bits;

  assign unused_ent_bits = ^mem_rdata[OFF_W-1:1];
  assign hit       = entry_present(mem_rdata);
  assign ev_accept = req_valid && req_ready;
  assign ev_miss   = mem_rvalid && !hit &&
                     (state == ST_WAIT_PDE || state == ST_WAIT_PTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      lin_q   <= '0;
      tbase_q <= '0;
      fault_q <= 1'b0;
      phys_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          lin_q <= req_lin;
          if (paging_on) state <= ST_FETCH_PDE;
          else begin
            phys_q  <= req_lin;
            fault_q <= 1'b0;
            state   <= ST_DONE;
          end
        end
        ST_FETCH_PDE: if (mem_ready) state <= ST_WAIT_PDE;
        ST_WAIT_PDE: if (mem_rvalid) begin
          if (hit) begin
            tbase_q <= mem_rdata[ADDR_W-1:OFF_W];
            state   <= ST_FETCH_PTE;
          end else begin
            fault_q <= 1'b1;
            phys_q  <= '0;
            state   <= ST_DONE;
          end
        end
        ST_FETCH_PTE: if (mem_ready) state <= ST_WAIT_PTE;
        ST_WAIT_PTE: if (mem_rvalid) begin
          fault_q <= !hit;
          phys_q  <= hit ? page_phys(mem_rdata[ADDR_W-1:OFF_W], lin_q) : '0;
          state   <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    rsp_valid = (state == ST_DONE);
    rsp_fault = fault_q;
    rsp_phys  = phys_q;
    mem_valid = (state == ST_FETCH_PDE) || (state == ST_FETCH_PTE);
    case (state)
      ST_FETCH_PDE: mem_addr = dir_entry_addr(dir_base, lin_q);
      ST_FETCH_PTE: mem_addr = tbl_entry_addr(tbase_q, lin_q);
      default:      mem_addr = '0;
    endcase
  end
endmodule

// File: rtl/ptw_two_level.sv
module ptw_two_level
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [ADDR_W-1:0] ctrl_wdata,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata
);
  logic              paging_on;
  logic [BASE_W-1:0] dir_base;
  logic              ev_accept;
  logic              ev_miss;

  pw_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_allow(req_ready),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .base_we(base_we), .base_wdata(base_wdata),
    .paging_on(paging_on), .dir_base(dir_base)
  );

  pw_walk u_walk (
    .clk(clk), .rst(rst), .paging_on(paging_on), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_phys(rsp_phys),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ev_accept(ev_accept), .ev_miss(ev_miss)
  );
endmodule

// File: rtl/pw_chk.sv
module pw_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic [31:0] req_lin,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] rsp_phys,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic        ctrl_we,
  input logic        paging_on,
  input logic        ev_accept,
  input logic        ev_miss
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> req_ready && !mem_valid && !rsp_valid && !paging_on);
  // R2
  bypass_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ev_accept && !paging_on |=> rsp_valid && !rsp_fault && rsp_phys == $past(req_lin));
  // R8
  fault_zero_phys_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_phys == 32'd0);
  // R8
  miss_ends_walk_chk: assert property (@(posedge clk) disable iff (rst)
    ev_miss |=> rsp_valid && rsp_fault);
  // R9
  hold_request_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));
  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid || rsp_valid |-> !req_ready);
  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready && ctrl_we |=> paging_on == $past(paging_on));
  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind ptw_two_level pw_chk u_pw_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .req_lin(req_lin),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_phys(rsp_phys),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .ctrl_we(ctrl_we), .paging_on(paging_on),
  .ev_accept(ev_accept), .ev_miss(ev_miss)
);

// File: tb/test_ptw_two_level.sv
module test_ptw_two_level;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0, base_we = 1'b0, req_valid = 1'b0;
  logic [31:0] ctrl_wdata = '0, base_wdata = '0, req_lin = '0;
  logic        req_ready, rsp_valid, rsp_fault, mem_valid;
  logic [31:0] rsp_phys, mem_addr;
  logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mem [logic [31:0]];
  logic [19:0] tb_base;

  always #(CLK_P/2) clk = ~clk;

  ptw_two_level i_ptw_two_level (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .base_we(base_we), .base_wdata(base_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_lin(req_lin), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_phys(rsp_phys), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  // memory responder with random handshake and data delays
  logic        pend = 0;
  logic [31:0] paddr = '0;
  int          dly = 0;
  int          fcnt = 0;
  logic [31:0] flog [256];
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_ready  <= ($urandom % 4) != 0;
    if (rst) pend <= 1'b0;
    else if (pend) begin
      if (dly == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(paddr);
        pend       <= 1'b0;
      end else dly <= dly - 1;
    end else if (mem_valid && mem_ready) begin
      pend  <= 1'b1;
      paddr <= mem_addr;
      dly   <= $urandom % 3;
    end
    if (!rst && mem_valid && mem_ready) begin
      flog[fcnt % 256] <= mem_addr;
      fcnt <= fcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench restatement of the walk
  task automatic model(input logic [31:0] lin, input bit pg, output bit f, output logic [31:0] p,
                       output int nf, output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] d, t;
    a0 = '0; a1 = '0;
    if (!pg) begin f = 0; p = lin; nf = 0; return; end
    a0 = (32'(tb_base) << 12) | (32'(lin >> 22) << 2);
    d  = rd(a0); nf = 1;
    if (d[0] == 1'b0) begin f = 1; p = 0; return; end
    a1 = (d & 32'hFFFF_F000) | (((lin >> 12) & 32'h3FF) << 2);
    t  = rd(a1); nf = 2;
    if (t[0] == 1'b0) begin f = 1; p = 0; return; end
    f = 0; p = (t & 32'hFFFF_F000) | (lin & 32'hFFF);
  endtask

  task automatic cfg_write(input bit is_ctrl, input logic [31:0] v);
    @(negedge clk);
    if (is_ctrl) begin ctrl_we = 1; ctrl_wdata = v; end
    else begin base_we = 1; base_wdata = v; end
    @(negedge clk);
    ctrl_we = 0; base_we = 0;
  endtask

  // pg: the bench's expectation of paging state; poke: try writes and a request while busy
  task automatic xlate(input logic [31:0] lin, input bit pg, input bit poke, input string tag);
    bit ef; logic [31:0] ep, a0, a1; int enf, base_n, cyc, n; bit busy_ok;
    model(lin, pg, ef, ep, enf, a0, a1);
    @(negedge clk);
    base_n = fcnt;
    req_valid = 1; req_lin = lin;
    @(negedge clk);
    req_valid = 0;
    cyc = 1; busy_ok = 1;
    while (!rsp_valid && cyc < 300) begin
      if (req_ready) busy_ok = 0;
      if (poke && cyc == 1) begin
        ctrl_we = 1; ctrl_wdata = {~pg, 31'h0};
        base_we = 1; base_wdata = 32'h0F0F_F000;
        req_valid = 1; req_lin = ~lin;
      end else begin
        ctrl_we = 0; base_we = 0; req_valid = 0;
      end
      @(negedge clk);
      cyc++;
    end
    ctrl_we = 0; base_we = 0; req_valid = 0;
    n = fcnt - base_n;
    chk(rsp_valid, {tag, " rsp arrives"}, 32'(rsp_valid), 1);
    chk(rsp_fault == ef, {tag, " R7/R8 fault"}, 32'(rsp_fault), 32'(ef));
    chk(rsp_phys == ep, {tag, " R2/R7/R8 phys"}, rsp_phys, ep);
    chk(n == enf, {tag, " R2/R8 fetch count"}, n, enf);
    if (!pg) chk(cyc == 1, {tag, " R2 bypass latency"}, cyc, 1);
    else chk(busy_ok && !req_ready, {tag, " R10 busy not ready"}, 32'(busy_ok), 1);
    if (enf >= 1 && n >= 1) chk(flog[base_n % 256] == a0, {tag, " R5 pde addr"}, flog[base_n % 256], a0);
    if (enf == 2 && n == 2) chk(flog[(base_n+1) % 256] == a1, {tag, " R6 pte addr"}, flog[(base_n+1) % 256], a1);
    @(negedge clk);
    chk(!rsp_valid && req_ready, {tag, " R12 single pulse"}, 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    tb_base = 20'h00200;
    // directory: entries 0..7 present except 5, each pointing to its own table
    for (int k = 0; k < 8; k++)
      if (k != 5) mem[32'h0020_0000 + 32'(k) * 4] = 32'h0020_1000 + 32'(k) * 32'h1000 + 32'h7;
      else        mem[32'h0020_0000 + 32'(k) * 4] = 32'h0030_1006;
    mem[32'h0020_1000 + 32'h3 * 4] = 32'hABCD_E003;   // dir 0, table idx 3: present page
    mem[32'h0020_1000 + 32'h4 * 4] = 32'hABCD_F006;   // dir 0, table idx 4: not present

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_valid, "R1 reset outputs", {29'b0, req_ready, rsp_valid, mem_valid}, 32'h4);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_valid, "R1 after reset", {29'b0, req_ready, rsp_valid, mem_valid}, 32'h4);

    xlate(32'hDEAD_BEEF, 0, 0, "R2 bypass");
    cfg_write(1, 32'h7FFF_FFFF);            // bit 31 clear: R3 stays off
    xlate(32'h0000_3123, 0, 0, "R3 low bits no enable");
    cfg_write(0, 32'h0020_0ABC);            // R4 low bits dropped
    cfg_write(1, 32'h8000_0000);            // R3 enable
    xlate(32'h0000_3123, 1, 0, "R4/R5 present page");
    xlate(32'h0000_4FFF, 1, 0, "R8 pte absent");
    xlate(32'h0140_0000, 1, 0, "R8 pde absent");
    xlate(32'hFFFF_FFFF, 1, 0, "R8 top dir");
    xlate(32'h0000_3ABC, 1, 1, "R11 poke during walk");
    xlate(32'h0000_3001, 1, 0, "R11 still paged");

    for (int i = 0; i < 80; i++) begin
      logic [31:0] lin;
      logic [31:0] ta;
      lin = {7'b0, 3'($urandom % 8), 10'($urandom), 12'($urandom)};
      ta = 32'h0020_1000 + 32'(lin[24:22]) * 32'h1000 + 32'(lin[21:12]) * 4;
      if (!mem.exists(ta))
        mem[ta] = {20'($urandom), 11'($urandom), 1'(($urandom % 5) != 0)};
      xlate(lin, 1, 0, "R5/R6/R7 random");
    end

    cfg_write(1, 32'h0000_0000);
    xlate(32'h1234_5678, 0, 0, "R3 disable bypass");
    cfg_write(1, 32'h8000_0000);
    rst = 1;
    @(negedge clk);
    rst = 0;
    xlate(32'h0000_3123, 0, 0, "R1 reset clears enable");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule